// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block keeps the event status and the interrupt enables of a card host controller. It also raises one interrupt line toward the processor. Hardware event sources inside the controller pulse one line each: card inserted, card removed, command finished, command timed out, data phase finished, CRC error, data timeout, receive overflow, transmit underrun, receive data ready and transmit data wanted. Each pulse latches a bit in a 32-bit status register. A separate 32-bit mask register decides which latched bits may reach the interrupt line. The status word also carries a live copy of the card's write-protect switch, which is not latched.

Both registers sit behind a 16-bit register bus, so each appears as two halfwords. Software acknowledges an event by writing 0 to its status bit. Every bit written as 1 is left alone, so an acknowledge writes the inverse of the bits to be cleared. The interrupt line stays high while any enabled, latched bit remains. A handler can therefore loop, reading and acknowledging, until the line falls.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, every latched status bit is 0, every mask bit is 1 and the interrupt output is 0.
- R2: A one-cycle event pulse on a latched bit sets that status bit at the next clock edge, and the bit stays set until software clears it. Latched bits: 0 command end, 2 data end, 3 card removed, 4 card inserted, 8 CRC error, 9 data timeout, 10 command timeout, 16 receive overflow, 17 transmit underrun, 24 receive ready, 25 transmit request.
- R3: A halfword write to the status register clears each latched bit written as 0 and leaves each bit written as 1 unchanged.
- R4: If an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: Each register is split across two halfword offsets: bits 15:0 at offset N and bits 31:16 at offset N+2. The status register is at byte offset 0x1C and the mask register at byte offset 0x20. Reads return the addressed halfword combinationally.
- R6: The mask register stores every written halfword as is and reads it back. A mask bit of 1 keeps its status bit from the interrupt, and a mask bit of 0 lets it through.
- R7: The interrupt output is a register. It goes high one clock after a status bit that is latched and unmasked exists, and it goes low one clock after none remains.
- R8: Status bit 5 reads as the current level of the write-protect input. It is never latched, status writes do not change it, and it never raises the interrupt.
- R9: Status bits outside the latched set and bit 5 always read 0, even when an event line for them pulses. Offsets other than the four register halfwords read 0, and writes to them change nothing.
- R10: Clearing one of several pending unmasked bits leaves the interrupt high until the last of them is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 9 | Byte offset of the halfword being accessed |
| reg_wr | input | 1 | Write strobe for the addressed halfword |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed halfword |
| evt_pulse | input | 32 | One-cycle event pulses, one line per status bit |
| wp_level | input | 1 | Live write-protect switch level |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The bench targets four cases:
- **Event and acknowledge on the same bit in one cycle.** A design that lets the write win loses that event for good.
- **Partial acknowledge with two pending bits.** Here the line must stay high. A design that drops it loses the second event.
- **Upper halfwords of both registers.** A swapped or misdecoded half clears or unmasks the wrong sources.
- **Write-protect bit.** Once software writes to the status register, the bit must still track the switch, and it must not interrupt even with every mask bit open. A latched or writable copy of it would go stale or raise false interrupts.

// File: rtl/isu_pkg.sv
// Shared constants and types of the interrupt status unit.
// Assumes a 32-bit status word reached through a 16-bit register bus.
package isu_pkg;
    localparam int HW_W    = 16;
    localparam int REG_W   = 32;
    localparam int HALVES  = REG_W / HW_W;

    // Status bit positions
    localparam int B_CMD_END  = 0;
    localparam int B_DAT_END  = 2;
    localparam int B_CARD_OUT = 3;
    localparam int B_CARD_IN  = 4;
    localparam int B_WPROT    = 5;
    localparam int B_CRC_ERR  = 8;
    localparam int B_DAT_TMO  = 9;
    localparam int B_CMD_TMO  = 10;
    localparam int B_RX_OVF   = 16;
    localparam int B_TX_UNDR  = 17;
    localparam int B_RX_RDY   = 24;
    localparam int B_TX_REQ   = 25;

    localparam logic [REG_W-1:0] LATCHED =
        (REG_W'(1) << B_CMD_END) | (REG_W'(1) << B_DAT_END) |
        (REG_W'(1) << B_CARD_OUT) | (REG_W'(1) << B_CARD_IN) |
        (REG_W'(1) << B_CRC_ERR) | (REG_W'(1) << B_DAT_TMO) |
        (REG_W'(1) << B_CMD_TMO) | (REG_W'(1) << B_RX_OVF) |
        (REG_W'(1) << B_TX_UNDR) | (REG_W'(1) << B_RX_RDY) |
        (REG_W'(1) << B_TX_REQ);

    // Bits allowed to reach the interrupt line (the live level is excluded)
    localparam logic [REG_W-1:0] IRQ_SRC = LATCHED;

    typedef enum logic [2:0] {
        RD_NONE, RD_STAT_LO, RD_STAT_HI, RD_MASK_LO, RD_MASK_HI
    } rd_sel_e;
endpackage

// File: rtl/isu_decode.sv
// Halfword address decoder: turns a byte offset and write strobe into
// per-halfword write enables for both registers and a read selector.
// Assumes offsets are halfword aligned; any other offset selects nothing.
module isu_decode
    import isu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] STAT_OFS = 9'h01C,
    parameter logic [ADDR_W-1:0] MASK_OFS = 9'h020
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [HALVES-1:0] stat_we,
    output logic [HALVES-1:0] mask_we,
    output rd_sel_e           rd_sel
);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(HW_W / 8);

    // Match the offset against each halfword of each register
    always_comb begin
        stat_we = '0;
        mask_we = '0;
        rd_sel  = RD_NONE;
        if (addr == STAT_OFS) begin
            stat_we[0] = wr;
            rd_sel     = RD_STAT_LO;
        end else if (addr == STAT_OFS + HALF_STEP) begin
            stat_we[1] = wr;
            rd_sel     = RD_STAT_HI;
        end else if (addr == MASK_OFS) begin
            mask_we[0] = wr;
            rd_sel     = RD_MASK_LO;
        end else if (addr == MASK_OFS + HALF_STEP) begin
            mask_we[1] = wr;
            rd_sel     = RD_MASK_HI;
        end
    end
endmodule

// File: rtl/isu_status_reg.sv
// Latched event status. Pulses set bits; halfword writes clear bits
// written as 0. A pulse beats a clear on the same bit in the same cycle.
// Assumes pulses last one cycle; only the LATCHED bits have storage.
module isu_status_reg
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt,
    input  logic [HALVES-1:0] we,
    input  logic [HW_W-1:0]   wdata,
    output logic [REG_W-1:0]  stat_q
);
    logic [REG_W-1:0] keep;
    logic [REG_W-1:0] stat_d;

    // Build the keep vector: written halfwords keep only their 1 bits
    always_comb begin
        keep = '1;
        for (int h = 0; h < HALVES; h++) begin
            if (we[h]) keep[h*HW_W +: HW_W] = wdata;
        end
        stat_d = ((stat_q & keep) | evt) & LATCHED;
    end

    // Status storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & LATCHED) != '0) |=> ((stat_q & $past(evt & LATCHED)) == $past(evt & LATCHED))); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0)); // R2
    AST_ONLY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~LATCHED) == '0)); // R9
endmodule

// File: rtl/isu_mask_reg.sv
// Interrupt enable mask, 1 = source blocked. Halfword loadable.
// Assumes a reset value of all ones so every source starts blocked.
module isu_mask_reg
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALVES-1:0] we,
    input  logic [HW_W-1:0]   wdata,
    output logic [REG_W-1:0]  mask_q
);
    // One storage slice per halfword
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n)     mask_q[h*HW_W +: HW_W] <= '1;
            else if (we[h]) mask_q[h*HW_W +: HW_W] <= wdata;
        end
    end

    AST_MASK_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> (mask_q[HW_W-1:0] == $past(wdata))); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we == '0) |=> $stable(mask_q)); // R6
endmodule

// File: rtl/isu_irq_gen.sv
// Interrupt generator: ORs the latched, unmasked bits into one
// registered active-high line, so the output cannot glitch.
// Assumes status and mask come straight from registers.
module isu_irq_gen
    import isu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat,
    input  logic [REG_W-1:0] mask,
    output logic             irq_q
);
    logic [REG_W-1:0] pending;

    // Pending vector: latched, allowed and not masked
    always_comb pending = stat & IRQ_SRC & ~mask;

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pending;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |=> irq_q); // R7
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> !irq_q); // R10
endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status unit: address decode, latched status,
// mask and interrupt generation, plus the halfword read mux.
// Assumes a 16-bit register bus with combinational reads.
module irq_status_unit
    import isu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] STAT_OFS = 9'h01C,
    parameter logic [ADDR_W-1:0] MASK_OFS = 9'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [HW_W-1:0]   reg_wdata,
    output logic [HW_W-1:0]   reg_rdata,
    input  logic [REG_W-1:0]  evt_pulse,
    input  logic              wp_level,
    output logic              irq
);
    logic [HALVES-1:0] stat_we;
    logic [HALVES-1:0] mask_we;
    rd_sel_e           rd_sel;
    logic [REG_W-1:0]  stat_q;
    logic [REG_W-1:0]  mask_q;
    logic [REG_W-1:0]  stat_view;

    isu_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
        .addr(reg_addr), .wr(reg_wr), .stat_we(stat_we), .mask_we(mask_we), .rd_sel(rd_sel)
    );

    isu_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .we(stat_we),
        .wdata(reg_wdata), .stat_q(stat_q)
    );

    isu_mask_reg u_mask (
        .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(reg_wdata), .mask_q(mask_q)
    );

    isu_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .stat(stat_q), .mask(mask_q), .irq_q(irq)
    );

    // Merge the live write-protect level into the visible status word
    always_comb begin
        stat_view = stat_q;
        stat_view[B_WPROT] = wp_level;
    end

    // Halfword read mux
    always_comb begin
        unique case (rd_sel)
            RD_STAT_LO: reg_rdata = stat_view[HW_W-1:0];
            RD_STAT_HI: reg_rdata = stat_view[REG_W-1:HW_W];
            RD_MASK_LO: reg_rdata = mask_q[HW_W-1:0];
            RD_MASK_HI: reg_rdata = mask_q[REG_W-1:HW_W];
            default:    reg_rdata = '0;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1
    AST_WP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~mask_q & ~(REG_W'(1) << B_WPROT)) == '0) |=> !irq); // R8
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic        wp_level = 1'b0;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference model state
    logic [31:0] m_stat = '0;
    logic [31:0] m_mask = '1;
    logic        m_irq  = 1'b0;
    localparam logic [31:0] M_LATCH = 32'h0303_071D;

    always #10 clk = ~clk;  // 50 MHz

    irq_status_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .wp_level(wp_level), .irq(irq)
    );

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        logic [31:0] clr;
        logic        nirq;
        if (!rst_n) begin
            m_stat = '0; m_mask = '1; m_irq = 1'b0;
        end else begin
            nirq = ((m_stat & M_LATCH & ~m_mask) != 0);
            clr = '1;
            if (reg_wr && reg_addr == 9'h01C) clr[15:0]  = reg_wdata;
            if (reg_wr && reg_addr == 9'h01E) clr[31:16] = reg_wdata;
            m_stat = ((m_stat & clr) | evt_pulse) & M_LATCH;
            if (reg_wr && reg_addr == 9'h020) m_mask[15:0]  = reg_wdata;
            if (reg_wr && reg_addr == 9'h022) m_mask[31:16] = reg_wdata;
            m_irq = nirq;
        end
    end

    function automatic logic [15:0] exp_read(input logic [8:0] a);
        logic [31:0] v;
        v = m_stat;
        v[5] = wp_level;
        case (a)
            9'h01C:  return v[15:0];
            9'h01E:  return v[31:16];
            9'h020:  return m_mask[15:0];
            9'h022:  return m_mask[31:16];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (irq !== m_irq) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b t=%0t", tag, irq, m_irq, $time);
        end
        vectors++;
        if (reg_rdata !== exp_read(reg_addr)) begin
            errors++;
            $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t",
                     tag, reg_addr, reg_rdata, exp_read(reg_addr), $time);
        end
    endtask

    // One cycle: check outputs for the current bus, then drive the next one
    task automatic step(input string tag, input logic [8:0] a, input logic w,
                        input logic [15:0] d, input logic [31:0] e, input logic p);
        @(negedge clk);
        compare(tag);
        reg_addr = a; reg_wr = w; reg_wdata = d; evt_pulse = e; wp_level = p;
    endtask

    task automatic idle(input string tag, input logic [8:0] a, input int n);
        for (int i = 0; i < n; i++) step(tag, a, 1'b0, 16'h0, 32'h0, wp_level);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        idle("R1 status", 9'h01C, 1);
        idle("R1 mask lo", 9'h020, 1);
        idle("R1 mask hi", 9'h022, 1);

        // R6: event while masked does not interrupt
        step("R2 insert", 9'h01C, 1'b0, 16'h0, 32'h0000_0010, 1'b0);
        idle("R6 masked", 9'h01C, 3);
        // R6/R7: unmask bit 4, irq rises one clock later
        step("R6 unmask", 9'h020, 1'b1, 16'hFFEF, 32'h0, 1'b0);
        idle("R7 rise", 9'h020, 3);
        // R3: acknowledge by writing inverse
        step("R3 clear", 9'h01C, 1'b1, 16'hFFEF, 32'h0, 1'b0);
        idle("R7 fall", 9'h01C, 3);
        // R3: writing all ones leaves bits
        step("R2 cmd end", 9'h01C, 1'b0, 16'h0, 32'h0000_0001, 1'b0);
        step("R3 ones", 9'h01C, 1'b1, 16'hFFFF, 32'h0, 1'b0);
        idle("R3 kept", 9'h01C, 2);
        // R10: two pending, clear one
        step("R6 unmask0", 9'h020, 1'b1, 16'hFFEE, 32'h0, 1'b0);
        step("R10 set4", 9'h01C, 1'b0, 16'h0, 32'h0000_0010, 1'b0);
        idle("R10 both", 9'h01C, 2);
        step("R10 clr0", 9'h01C, 1'b1, 16'hFFFE, 32'h0, 1'b0);
        idle("R10 hold", 9'h01C, 3);
        // R4: event and clear on the same bit in one cycle
        step("R4 race", 9'h01C, 1'b1, 16'hFFEF, 32'h0000_0010, 1'b0);
        idle("R4 wins", 9'h01C, 3);
        step("R3 final", 9'h01C, 1'b1, 16'h0000, 32'h0, 1'b0);
        idle("R3 empty", 9'h01C, 3);
        // R5: upper halfwords
        step("R5 rx rdy", 9'h01E, 1'b0, 16'h0, 32'h0100_0000, 1'b0);
        idle("R5 hi read", 9'h01E, 2);
        step("R5 unmask hi", 9'h022, 1'b1, 16'hFEFF, 32'h0, 1'b0);
        idle("R5 irq hi", 9'h022, 3);
        step("R5 lo no-op", 9'h01C, 1'b1, 16'h0000, 32'h0, 1'b0);
        idle("R5 still", 9'h01E, 2);
        step("R5 clr hi", 9'h01E, 1'b1, 16'hFEFF, 32'h0, 1'b0);
        idle("R5 cleared", 9'h01E, 3);
        // R8: write-protect live level, open mask entirely
        step("R8 open lo", 9'h020, 1'b1, 16'h0000, 32'h0, 1'b1);
        step("R8 open hi", 9'h022, 1'b1, 16'h0000, 32'h0, 1'b1);
        idle("R8 level", 9'h01C, 3);
        step("R8 write0", 9'h01C, 1'b1, 16'h0000, 32'h0000_0020, 1'b1);
        idle("R8 live", 9'h01C, 3);
        step("R8 drop", 9'h01C, 1'b0, 16'h0, 32'h0, 1'b0);
        idle("R8 follows", 9'h01C, 2);
        // R9: unused bits and unmapped offsets
        step("R9 unused", 9'h01E, 1'b0, 16'h0, 32'h8000_4000, 1'b0);
        idle("R9 reads0", 9'h01E, 2);
        step("R9 wr 024", 9'h024, 1'b1, 16'h1234, 32'h0, 1'b0);
        idle("R9 rd 024", 9'h024, 2);
        idle("R9 mask kept", 9'h020, 2);
        // R1: reset again restores everything
        step("R2 many", 9'h01C, 1'b0, 16'h0, 32'h0303_071D, 1'b0);
        idle("R7 many", 9'h01C, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare("R1 re-reset");
        rst_n = 1'b1;
        idle("R1 after", 9'h020, 2);
        idle("R1 after st", 9'h01C, 2);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule